// File: doc/BRIEF.md
# Cascadable Serial-In Latched-Output Register

The block turns a serial bit stream into a parallel word that is held steady at the outputs. Bits enter on a serial input and move one stage per rising edge of a shift clock. A separate register clock copies the whole shift stage into a storage stage in one step. The parallel outputs show the storage stage through an output gate. An active-high output enable forces every output bit to 0, which means the driver for that channel is off. A 1 on an output bit means the channel sinks current.

An active-low clear empties the shift stage at once and leaves the storage stage alone. The last shift stage also appears on a serial output, so several units can be chained into one longer register. The shift clock and the register clock are inputs sampled in a single system clock domain. A rising edge on either of them takes effect at the system clock edge that first sees the high level.

Top module: `latched_shift_reg`

## Requirements
- R1: After rst_ni is released, with no shift or register clock edge seen since, par_o and ser_o are all 0.
- R2: At a system clock edge that sees a rising edge of shift_clk_i, with clr_ni high, every shift bit k moves to bit k+1 and ser_i enters bit 0. The shift stage holds at every other edge.
- R3: At a system clock edge that sees a rising edge of store_clk_i, the storage stage takes the shift contents that were present before that edge. This holds even when a shift edge is seen in the same cycle. Without a register clock edge the storage stage holds.
- R4: While clr_ni is low, the shift stage reads all zeros at once, without waiting for a clock edge, and shift edges have no effect.
- R5: clr_ni has no effect on the storage stage or on par_o.
- R6: While oe_i is high, par_o is 0. Both stages keep their contents, and the stored word reappears when oe_i returns low.
- R7: While oe_i is low, par_o equals the storage stage, with no cycle of delay from oe_i.
- R8: ser_o is shift bit WIDTH-1. When ser_o of one unit drives ser_i of the next, 2*WIDTH shifts followed by one register clock edge leave the first bit shifted in at the top bit of the second unit.
- R9: A shift clock held high for several system cycles causes exactly one shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples every input |
| rst_ni | input | 1 | Asynchronous active-low reset of all state |
| ser_i | input | 1 | Serial data in |
| shift_clk_i | input | 1 | Shift clock; its rising edge moves the shift stage |
| store_clk_i | input | 1 | Register clock; its rising edge loads the storage stage |
| clr_ni | input | 1 | Asynchronous active-low clear of the shift stage only |
| oe_i | input | 1 | Output enable; high forces all parallel outputs off |
| par_o | output | WIDTH | Gated parallel outputs; 1 means the channel sinks current |
| ser_o | output | 1 | Last shift stage, used for cascading |

## Verification
The bench chains two units and shifts several 16-bit words through them: 0x1234, a word extended by a held shift clock, 0xBEEF and a walking pattern. These words show whether the bit order is correct, whether bits cross the unit boundary, and whether the shift acts on the edge or on the level. A shift edge and a register clock edge in the same cycle show whether the storage stage takes the contents from before the shift. The clear and enable sequences show that each one touches only its own stage or gate. In the clear sequence, shift attempts are made while clr_ni is low, followed by a store. Every cycle, par_o and ser_o are also compared against a behavioural 16-bit model.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int unsigned LSR_DEF_WIDTH = 8;
  localparam int unsigned LSR_NUM_CLKS  = 2;
  localparam int unsigned LSR_IDX_SHIFT = 0;
  localparam int unsigned LSR_IDX_STORE = 1;
endpackage

// File: rtl/lsr_edge.sv
module lsr_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;

  assign rise_o = lvl_i & ~prev_q;

  AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R9
endmodule

// File: rtl/lsr_shift.sv
module lsr_shift #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_ni,
  input  logic             en_i,
  input  logic             ser_i,
  output logic [WIDTH-1:0] sh_o
);
  logic [WIDTH-1:0] sh_q;

  // clear reaches this stage only
  always_ff @(posedge clk_i or negedge rst_ni or negedge clr_ni)
    if (!rst_ni || !clr_ni) sh_q <= '0;
    else if (en_i)          sh_q <= {sh_q[WIDTH-2:0], ser_i};

  assign sh_o = sh_q;

  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> sh_q == '0); // R4
  AST_SHIFT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && clr_ni) |=> (!clr_ni || sh_q == {$past(sh_q[WIDTH-2:0]), $past(ser_i)})); // R2
  AST_SHIFT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && clr_ni) |=> (!clr_ni || $stable(sh_q))); // R2
endmodule

// File: rtl/lsr_store.sv
module lsr_store #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] st_o
);
  logic [WIDTH-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    st_q <= '0;
    else if (cap_i) st_q <= d_i;

  assign st_o = st_q;

  AST_STORE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> st_q == $past(d_i)); // R3
  AST_STORE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(st_q)); // R5
endmodule

// File: rtl/latched_shift_reg.sv
module latched_shift_reg
  import lsr_pkg::*;
#(
  parameter int unsigned WIDTH = LSR_DEF_WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_i,
  input  logic             shift_clk_i,
  input  logic             store_clk_i,
  input  logic             clr_ni,
  input  logic             oe_i,
  output logic [WIDTH-1:0] par_o,
  output logic             ser_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [LSR_NUM_CLKS-1:0] lvl, rise;
  logic [WIDTH-1:0]        sh, st;

  assign lvl[LSR_IDX_SHIFT] = shift_clk_i;
  assign lvl[LSR_IDX_STORE] = store_clk_i;

  for (genvar g = 0; g < LSR_NUM_CLKS; g++) begin : g_edge
    lsr_edge u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (lvl[g]),
      .rise_o (rise[g])
    );
  end

  lsr_shift #(.WIDTH(WIDTH)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_ni (clr_ni),
    .en_i   (rise[LSR_IDX_SHIFT]),
    .ser_i  (ser_i),
    .sh_o   (sh)
  );

  lsr_store #(.WIDTH(WIDTH)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (rise[LSR_IDX_STORE]),
    .d_i    (sh),
    .st_o   (st)
  );

  assign par_o = oe_i ? '0 : st;
  assign ser_o = sh[MSB];

  AST_OE_BLANKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_i |-> par_o == '0); // R6
  AST_CLR_KEEPS_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_ni && !oe_i && $past(!oe_i) && !rise[LSR_IDX_STORE] && !$past(rise[LSR_IDX_STORE]))
    |-> $stable(par_o)); // R5
  AST_CLR_SER_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> !ser_o); // R8
endmodule

// File: tb/sim_latched_shift_reg.sv
`timescale 1ns/1ps
module sim_latched_shift_reg;
  localparam int W = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ser = 1'b0, shclk = 1'b0, stclk = 1'b0, clr_n = 1'b1, oe = 1'b0;
  logic [W-1:0] par0, par1;
  logic ser0, ser1;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  latched_shift_reg #(.WIDTH(W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ser_i(ser), .shift_clk_i(shclk),
    .store_clk_i(stclk), .clr_ni(clr_n), .oe_i(oe), .par_o(par0), .ser_o(ser0));
  latched_shift_reg #(.WIDTH(W)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .ser_i(ser0), .shift_clk_i(shclk),
    .store_clk_i(stclk), .clr_ni(clr_n), .oe_i(oe), .par_o(par1), .ser_o(ser1));

  // behavioural model of the 16-bit chain
  logic [15:0] m_sh = '0, m_st = '0;
  logic p_sh = 1'b0, p_st = 1'b0;

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_sh = '0; m_st = '0; p_sh = 1'b0; p_st = 1'b0;
    end else begin
      logic [15:0] cur;
      cur = clr_n ? m_sh : 16'h0;
      if (stclk && !p_st) m_st = cur;
      if (!clr_n)              m_sh = '0;
      else if (shclk && !p_sh) m_sh = {cur[14:0], ser};
      p_sh = shclk; p_st = stclk;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_ni && !done) begin
    logic [15:0] e_sh;
    e_sh = clr_n ? m_sh : 16'h0;
    chk("R7 par vs model", {par1, par0}, oe ? 16'h0 : m_st);
    chk("R8 ser vs model", {14'h0, ser1, ser0}, {14'h0, e_sh[15], e_sh[7]});
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic shift_bit(input logic b);
    ser = b; shclk = 1'b1; tick(1);
    shclk = 1'b0; tick(1);
  endtask
  task automatic shift_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) shift_bit(w[i]);
  endtask
  task automatic store();
    stclk = 1'b1; tick(1);
    stclk = 1'b0; tick(1);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(2);
    chk("R1 par after reset", {par1, par0}, 16'h0);
    chk("R1 ser after reset", {14'h0, ser1, ser0}, 16'h0);

    shift_word(16'h1234);
    chk("R3 no store yet", {par1, par0}, 16'h0);
    store();
    chk("R2 R8 cascade word", {par1, par0}, 16'h1234);

    // held shift clock: one shift only
    ser = 1'b1; shclk = 1'b1; tick(4);
    shclk = 1'b0; tick(1);
    store();
    chk("R9 level gives one shift", {par1, par0}, 16'h2469);

    oe = 1'b1; #1;
    chk("R6 oe blanks", {par1, par0}, 16'h0);
    store();
    chk("R6 blanked during store", {par1, par0}, 16'h0);
    oe = 1'b0; #1;
    chk("R7 oe low same cycle", {par1, par0}, 16'h2469);
    chk("R6 contents kept", {par1, par0}, 16'h2469);

    shift_word(16'h8001);
    chk("R8 ser top after 8001", {15'h0, ser1}, 16'h1);
    clr_n = 1'b0; #1;
    chk("R4 clear async ser", {14'h0, ser1, ser0}, 16'h0);
    chk("R5 clear keeps par", {par1, par0}, 16'h2469);
    shift_bit(1'b1);
    shift_bit(1'b1);
    chk("R4 no shift while clear", {14'h0, ser1, ser0}, 16'h0);
    clr_n = 1'b1; tick(1);
    chk("R5 par after clear", {par1, par0}, 16'h2469);
    store();
    chk("R4 cleared stage stored", {par1, par0}, 16'h0);

    shift_word(16'hBEEF);
    ser = 1'b0; shclk = 1'b1; stclk = 1'b1; tick(1);
    shclk = 1'b0; stclk = 1'b0; tick(1);
    chk("R3 same-cycle store takes old", {par1, par0}, 16'hBEEF);
    store();
    chk("R2 shifted after coincident edge", {par1, par0}, 16'h7DDE);

    shift_word(16'h8001);
    store();
    chk("R2 walking ends", {par1, par0}, 16'h8001);
    shift_word(16'hFFFF);
    store();
    chk("R8 all ones", {par1, par0}, 16'hFFFF);

    tick(2);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule